// File: doc/BRIEF.md
# Real-Time Clock Control and Status Register Bank

This block holds the four control and status registers of a real-time clock on a byte-wide register bus. It decodes a three-bit oscillator mode field, and sequences the once-per-second update strobe from a clock-enable tick. It raises an update-in-progress flag shortly before each strobe and gathers interrupt flags into an interrupt request. It also blocks every register write while a power-fail input is high and for a recovery period after it drops. The timekeeping counters, the supply comparators, the backup-supply switch and the square-wave divider chain are outside the block. The block only drives the divider tap index, the periodic enable and the square-wave enable to those circuits.

The bus has no handshake. A write takes effect at the clock edge where `wr_en` is high. Read data follows `addr` combinationally. A read of the flag register with `rd_en` high clears its flags at that edge. The periodic and alarm events arrive as one-cycle pulses from outside logic. The `tick` input is a one-cycle clock enable at the reference rate.

Top module: `rtc_ctrl_regs`

## Requirements
- R1: Registers respond at addresses 0x0A (mode), 0x0B (enables), 0x0C (flags) and 0x0D (battery), whether or not an update is pending. Any other address reads 0x00, and a write to any other address changes no register.
- R2: Mode register bits 6:4 hold the oscillator field and bits 3:0 hold the rate field. Both are read/write. Bit 7 reads the update-in-progress flag and ignores writes. The enables register is read/write on all eight bits. The flag and battery registers ignore writes.
- R3: Reset clears enables-register bits 6:3 and flag-register bits 7:4. Reset leaves the mode register bits 6:0 and enables-register bits 7 and 2:0 as they were.
- R4: Oscillator field 010 drives `osc_on`=1 and `div_en`=1. Field 110 or 111 drives `osc_on`=1 and `div_en`=0. Any other value drives both to 0.
- R5: Writing 010 into the oscillator field while it holds another value makes `upd_strobe` pulse for one clock on the START_DLY_TICKS-th tick after that write. Later strobes follow every TICKS_PER_SEC ticks.
- R6: While `div_en` is 0, `upd_strobe` stays 0 and the update-in-progress flag reads 0.
- R7: The update-in-progress flag (mode bit 7) rises on the tick that lies UIP_LEAD_TICKS ticks before a strobe. It reads 0 from the cycle in which the strobe is high.
- R8: While enables-register bit 7 (transfer inhibit) is 1, mode bit 7 reads 0. Strobes continue unchanged.
- R9: The flag register has bit 6 set by `per_evt`, bit 5 set by `alarm_evt` and bit 4 set by a strobe. Bit 7 is the OR of each flag ANDed with its enable (enables bits 6, 5 and 4). `irq` equals bit 7, and bits 3:0 read 0. A read of 0x0C with `rd_en` clears bits 6:4, except a flag whose event arrives in that same cycle.
- R10: Battery register bit 7 equals `batt_ok`, and bits 6:0 read 0.
- R11: While `pwr_fail` is 1, every write is ignored. Writes stay ignored until RECOV_TICKS ticks have passed after `pwr_fail` falls.
- R12: With rate field value r, `per_en` is 1 exactly when r≠0 and `rate_tap` is entry r of RATE_LUT. The default entries are 0 for r=0, 7 for r=1, 8 for r=2 and r−1 for r=3..15 (13 distinct rates). `sqw_en` equals enables bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle clock enable at the reference rate |
| pwr_fail | input | 1 | Supply out of tolerance, blocks writes |
| batt_ok | input | 1 | Backup energy valid |
| per_evt | input | 1 | Periodic event pulse |
| alarm_evt | input | 1 | Alarm match pulse |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, clears flags at 0x0C |
| rd_data | output | 8 | Read data for `addr` |
| osc_on | output | 1 | Oscillator enable |
| div_en | output | 1 | Divider running |
| upd_strobe | output | 1 | One-cycle once-per-second update pulse |
| irq | output | 1 | Interrupt request |
| sqw_en | output | 1 | Square-wave output enable |
| per_en | output | 1 | Periodic event enabled |
| rate_tap | output | 4 | Divider tap index for the chosen rate |

## Verification
The bench builds the block with 16 ticks per second, a start delay of 8 ticks, a lead of 3 ticks and a recovery of 5 ticks. With these values several full update periods, the start delay and the lead window fit into a few hundred cycles. This lets the bench check the strobe and the update-in-progress flag tick by tick against a position computed modulo 16. The small setting also allows full sweeps of all 256 addresses, all 16 rate codes, all 8 oscillator codes and all combinations of the three enables with both event inputs. The recovery window can be probed one tick short and at its end.

// File: rtl/rtc_regs_pkg.sv
package rtc_regs_pkg;
  localparam logic [7:0] ADDR_MODE = 8'h0A;
  localparam logic [7:0] ADDR_ENAB = 8'h0B;
  localparam logic [7:0] ADDR_FLAG = 8'h0C;
  localparam logic [7:0] ADDR_BATT = 8'h0D;

  localparam logic [2:0] OSC_RUN = 3'b010;

  // Tap index per rate code: codes 1 and 2 alias mid-range taps,
  // codes 3..15 step one halving each.
  function automatic logic [63:0] default_rate_lut();
    logic [63:0] t;
    logic [3:0]  v;
    t = '0;
    for (int i = 1; i < 16; i++) begin
      if (i == 1)      v = 4'd7;
      else if (i == 2) v = 4'd8;
      else             v = 4'(i - 1);
      t[i*4 +: 4] = v;
    end
    return t;
  endfunction
endpackage

// File: rtl/rtc_regs_wlock.sv
module rtc_regs_wlock #(
  parameter int RECOV_TICKS = 6554
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pwr_fail,
  output logic locked
);
  localparam int RW = $clog2(RECOV_TICKS + 1);

  logic [RW-1:0] recov_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          recov_cnt <= '0;
    else if (pwr_fail)                   recov_cnt <= RW'(RECOV_TICKS);
    else if (tick && recov_cnt != '0)    recov_cnt <= recov_cnt - RW'(1);
  end

  assign locked = pwr_fail | (recov_cnt != '0);
endmodule

// File: rtl/rtc_regs_upd_seq.sv
module rtc_regs_upd_seq
  import rtc_regs_pkg::*;
#(
  parameter int TICKS_PER_SEC   = 32768,
  parameter int START_DLY_TICKS = 16384,
  parameter int UIP_LEAD_TICKS  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [2:0] osc_mode,
  input  logic       start,
  output logic       osc_on,
  output logic       div_en,
  output logic       upd_strobe,
  output logic       uip_raw
);
  localparam int            CW     = $clog2(TICKS_PER_SEC);
  localparam logic [CW-1:0] LAST   = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] LOAD   = CW'(TICKS_PER_SEC - START_DLY_TICKS);
  localparam logic [CW-1:0] UIP_AT = CW'(TICKS_PER_SEC - UIP_LEAD_TICKS);

  logic [CW-1:0] sec_pos;
  logic [CW-1:0] nxt_pos;

  assign div_en  = (osc_mode == OSC_RUN);
  assign osc_on  = div_en | (osc_mode[2:1] == 2'b11);
  assign nxt_pos = sec_pos + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_pos    <= '0;
      upd_strobe <= 1'b0;
      uip_raw    <= 1'b0;
    end else begin
      upd_strobe <= 1'b0;
      if (start) begin
        sec_pos <= LOAD;
        uip_raw <= 1'b0;
      end else if (!div_en) begin
        uip_raw <= 1'b0;
      end else if (tick) begin
        if (sec_pos == LAST) begin
          sec_pos    <= '0;
          upd_strobe <= 1'b1;
          uip_raw    <= 1'b0;
        end else begin
          sec_pos <= nxt_pos;
          if (nxt_pos == UIP_AT) uip_raw <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_regs_flags.sv
module rtc_regs_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       per_evt,
  input  logic       alarm_evt,
  input  logic       upd_evt,
  input  logic       clr,
  input  logic [2:0] enab,    // {periodic, alarm, update}
  output logic [3:0] flags    // {request, periodic, alarm, update}
);
  logic pf_q, af_q, uf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q <= 1'b0;
      af_q <= 1'b0;
      uf_q <= 1'b0;
    end else begin
      pf_q <= per_evt   | (pf_q & ~clr);
      af_q <= alarm_evt | (af_q & ~clr);
      uf_q <= upd_evt   | (uf_q & ~clr);
    end
  end

  assign flags = {|({pf_q, af_q, uf_q} & enab), pf_q, af_q, uf_q};
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_regs_pkg::*;
#(
  parameter int          TICKS_PER_SEC   = 32768,
  parameter int          START_DLY_TICKS = TICKS_PER_SEC / 2,
  parameter int          UIP_LEAD_TICKS  = 8,
  parameter int          RECOV_TICKS     = 6554,
  parameter logic [63:0] RATE_LUT        = rtc_regs_pkg::default_rate_lut()
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       pwr_fail,
  input  logic       batt_ok,
  input  logic       per_evt,
  input  logic       alarm_evt,
  input  logic [7:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       osc_on,
  output logic       div_en,
  output logic       upd_strobe,
  output logic       irq,
  output logic       sqw_en,
  output logic       per_en,
  output logic [3:0] rate_tap
);
  logic [6:0] mode_q;     // osc[6:4], rate[3:0]; kept through reset
  logic [3:0] keep_q;     // enables bits 7, 2, 1, 0; kept through reset
  logic [3:0] enab_q;     // enables bits 6..3; cleared by reset
  logic [7:0] enab_reg;
  logic [3:0] flag_q;
  logic       locked, wr_ok, wr_mode, start, uip_raw, uip_vis, flag_clr;

  assign wr_ok   = wr_en & ~locked;
  assign wr_mode = wr_ok & (addr == ADDR_MODE);
  assign start   = wr_mode & (wr_data[6:4] == OSC_RUN) & (mode_q[6:4] != OSC_RUN);
  assign enab_reg = {keep_q[3], enab_q, keep_q[2:0]};
  assign flag_clr = rd_en & (addr == ADDR_FLAG);

  always_ff @(posedge clk) begin
    if (wr_mode) mode_q <= wr_data[6:0];
    if (wr_ok && addr == ADDR_ENAB) keep_q <= {wr_data[7], wr_data[2:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          enab_q <= '0;
    else if (wr_ok && addr == ADDR_ENAB) enab_q <= wr_data[6:3];
  end

  rtc_regs_wlock #(.RECOV_TICKS(RECOV_TICKS)) u_wlock (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_fail(pwr_fail), .locked(locked)
  );

  rtc_regs_upd_seq #(
    .TICKS_PER_SEC(TICKS_PER_SEC), .START_DLY_TICKS(START_DLY_TICKS),
    .UIP_LEAD_TICKS(UIP_LEAD_TICKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .osc_mode(mode_q[6:4]), .start(start),
    .osc_on(osc_on), .div_en(div_en), .upd_strobe(upd_strobe), .uip_raw(uip_raw)
  );

  rtc_regs_flags u_flags (
    .clk(clk), .rst_n(rst_n), .per_evt(per_evt), .alarm_evt(alarm_evt),
    .upd_evt(upd_strobe), .clr(flag_clr), .enab(enab_q[3:1]), .flags(flag_q)
  );

  assign uip_vis  = uip_raw & ~keep_q[3];
  assign irq      = flag_q[3];
  assign sqw_en   = enab_q[0];
  assign per_en   = (mode_q[3:0] != 4'd0);
  assign rate_tap = RATE_LUT[{mode_q[3:0], 2'b00} +: 4];

  always_comb begin
    case (addr)
      ADDR_MODE: rd_data = {uip_vis, mode_q};
      ADDR_ENAB: rd_data = enab_reg;
      ADDR_FLAG: rd_data = {flag_q, 4'h0};
      ADDR_BATT: rd_data = {batt_ok, 7'h00};
      default:   rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_ctrl_regs_chk.sv
module rtc_ctrl_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] addr,
  input logic       wr_en,
  input logic       locked,
  input logic [6:0] mode_q,
  input logic [7:0] enab_reg,
  input logic [7:0] rd_data,
  input logic       div_en,
  input logic       upd_strobe,
  input logic       uip_raw,
  input logic       uf
);
  a_r8_uip_hidden_on_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 8'h0A && enab_reg[7]) |-> !rd_data[7]);

  a_r11_locked_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && locked) |=> (mode_q == $past(mode_q)) && (enab_reg == $past(enab_reg)));

  a_r6_no_strobe_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !div_en |=> !upd_strobe);

  a_r7_uip_low_at_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |-> !uip_raw);

  a_r5_strobe_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |=> !upd_strobe);

  a_r9_uf_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uf) |-> $past(upd_strobe));
endmodule

bind rtc_ctrl_regs rtc_ctrl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .locked(locked),
  .mode_q(mode_q), .enab_reg(enab_reg), .rd_data(rd_data), .div_en(div_en),
  .upd_strobe(upd_strobe), .uip_raw(uip_raw), .uf(flag_q[0])
);

// File: tb/rtc_ctrl_regs_tb.sv
module rtc_ctrl_regs_tb;
  localparam int TPS = 16, SDLY = 8, LEAD = 3, RECOV = 5;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, pwr_fail = 1'b0, batt_ok = 1'b0;
  logic per_evt = 1'b0, alarm_evt = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = 8'h00, wr_data = 8'h00;
  logic [7:0] rd_data;
  logic osc_on, div_en, upd_strobe, irq, sqw_en, per_en;
  logic [3:0] rate_tap;

  int n_chk = 0, n_err = 0, pos = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_ctrl_regs #(.TICKS_PER_SEC(TPS), .START_DLY_TICKS(SDLY),
                  .UIP_LEAD_TICKS(LEAD), .RECOV_TICKS(RECOV)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_fail(pwr_fail), .batt_ok(batt_ok),
    .per_evt(per_evt), .alarm_evt(alarm_evt), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .osc_on(osc_on),
    .div_en(div_en), .upd_strobe(upd_strobe), .irq(irq), .sqw_en(sqw_en),
    .per_en(per_en), .rate_tap(rate_tap));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1; cyc(); wr_en = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b0; #1; d = rd_data;
  endtask

  task automatic rd_clr(input logic [7:0] a);
    addr = a; rd_en = 1'b1; cyc(); rd_en = 1'b0;
  endtask

  task automatic do_tick();
    tick = 1'b1; cyc(); tick = 1'b0;
    pos = (pos + 1) % TPS;
  endtask

  task automatic run_ticks(input int n, input bool_running, input string tag);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      do_tick();
      peek(8'h0A, d);
      if (bool_running) begin
        check({tag, " R5 strobe"}, upd_strobe, (pos == 0));
        check({tag, " R7 uip"}, d[7], (pos >= TPS - LEAD));
      end else begin
        check({tag, " R6 strobe"}, upd_strobe, 0);
        check({tag, " R6 uip"}, d[7], 0);
      end
    end
  endtask

  function automatic logic [3:0] exp_tap(input int r);
    if (r == 0) return 4'd0;
    if (r == 1) return 4'd7;
    if (r == 2) return 4'd8;
    return 4'(r - 1);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc();

    // R3 reset state
    peek(8'h0C, d); check("R3 flags after reset", d, 8'h00);
    peek(8'h0B, d); check("R3 enables 6:3 after reset", d[6:3], 4'h0);
    check("R3 irq after reset", irq, 0);

    // R12 rate sweep, R2 mode read-back
    wr(8'h0B, 8'h00);
    for (int r = 0; r < 16; r++) begin
      wr(8'h0A, 8'(r));
      check("R12 rate_tap", rate_tap, exp_tap(r));
      check("R12 per_en", per_en, (r != 0));
      peek(8'h0A, d); check("R2 mode readback", d, 8'(r));
    end

    // R4 oscillator decode sweep
    for (int m = 0; m < 8; m++) begin
      wr(8'h0A, 8'(m << 4));
      check("R4 osc_on", osc_on, (m == 2) || (m >= 6));
      check("R4 div_en", div_en, (m == 2));
    end

    // R2 enables read/write, bit 7 of mode not writable, flag/batt ignore writes
    begin
      logic [7:0] pats [5] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h3C};
      for (int i = 0; i < 5; i++) begin
        wr(8'h0B, pats[i]);
        peek(8'h0B, d); check("R2 enables readback", d, pats[i]);
        check("R12 sqw_en", sqw_en, pats[i][3]);
      end
    end
    wr(8'h0B, 8'h00);
    wr(8'h0A, 8'h85);
    peek(8'h0A, d); check("R2 mode bit7 read-only", d, 8'h05);
    wr(8'h0C, 8'hFF);
    peek(8'h0C, d); check("R2 flags ignore write", d, 8'h00);
    check("R2 irq after flag write", irq, 0);
    wr(8'h0D, 8'hFF);
    peek(8'h0D, d); check("R2 batt ignore write", d, 8'h00);

    // R10 battery
    batt_ok = 1'b1; peek(8'h0D, d); check("R10 batt set", d, 8'h80);
    batt_ok = 1'b0; peek(8'h0D, d); check("R10 batt clear", d, 8'h00);

    // R1 address sweep
    for (int a = 0; a < 256; a++) begin
      if (a < 8'h0A || a > 8'h0D) begin
        wr(8'(a), 8'hFF);
        peek(8'(a), d); check("R1 unmapped reads zero", d, 8'h00);
      end
    end
    peek(8'h0A, d); check("R1 mode untouched", d, 8'h05);
    peek(8'h0B, d); check("R1 enables untouched", d, 8'h00);

    // R9 flag sweep: enables x events
    for (int en = 0; en < 8; en++) begin
      for (int ev = 0; ev < 4; ev++) begin
        logic pie, aie, pf, af;
        wr(8'h0B, 8'(en << 4));
        pie = en[2]; aie = en[1];
        pf = ev[0]; af = ev[1];
        per_evt = pf; alarm_evt = af; cyc(); per_evt = 0; alarm_evt = 0;
        peek(8'h0C, d);
        check("R9 flag byte", d, {(pf & pie) | (af & aie), pf, af, 5'b0});
        check("R9 irq", irq, (pf & pie) | (af & aie));
        rd_clr(8'h0C);
        peek(8'h0C, d); check("R9 cleared by read", d, 8'h00);
      end
    end
    // R9 event in the clearing cycle survives
    wr(8'h0B, 8'h00);
    per_evt = 1'b1; cyc();
    addr = 8'h0C; rd_en = 1'b1; alarm_evt = 1'b1; cyc();
    rd_en = 1'b0; per_evt = 1'b0; alarm_evt = 1'b0;
    peek(8'h0C, d); check("R9 set wins over clear", d, 8'h60);
    rd_clr(8'h0C);

    // R5/R7 start and periodic updates
    wr(8'h0A, 8'h00);
    wr(8'h0A, 8'h20);
    pos = TPS - SDLY;
    run_ticks(3 * TPS + SDLY, 1, "run");
    cyc();
    peek(8'h0C, d); check("R9 update flag", d, 8'h10);
    wr(8'h0B, 8'h10);
    peek(8'h0C, d); check("R9 update irq", d, 8'h90);
    check("R9 irq pin", irq, 1);
    rd_clr(8'h0C);

    // R8 transfer inhibit hides UIP, strobes go on
    wr(8'h0B, 8'h80);
    for (int k = 0; k < 2 * TPS; k++) begin
      do_tick();
      peek(8'h0A, d);
      check("R8 uip hidden", d[7], 0);
      check("R8 strobe continues", upd_strobe, (pos == 0));
    end
    wr(8'h0B, 8'h00);
    rd_clr(8'h0C);

    // R6 hold mode
    wr(8'h0A, 8'h60);
    check("R6 osc_on hold", osc_on, 1);
    check("R6 div_en hold", div_en, 0);
    run_ticks(2 * TPS + 3, 0, "hold");
    wr(8'h0A, 8'h20);
    pos = TPS - SDLY;
    run_ticks(TPS + SDLY, 1, "restart");

    // R11 write lock
    wr(8'h0A, 8'h00);
    pwr_fail = 1'b1;
    wr(8'h0B, 8'h7F);
    peek(8'h0B, d); check("R11 write during fail", d, 8'h00);
    repeat (3) do_tick();
    pwr_fail = 1'b0;
    cyc();
    repeat (RECOV - 1) do_tick();
    wr(8'h0B, 8'h7F);
    peek(8'h0B, d); check("R11 write in recovery", d, 8'h00);
    wr(8'h0A, 8'h33);
    peek(8'h0A, d); check("R11 mode in recovery", d, 8'h00);
    do_tick();
    wr(8'h0B, 8'h7F);
    peek(8'h0B, d); check("R11 write after recovery", d, 8'h7F);

    // R3 retention across reset
    wr(8'h0A, 8'h2F);
    wr(8'h0B, 8'hFF);
    per_evt = 1'b1; cyc(); per_evt = 1'b0;
    rst_n = 1'b0; cyc(); cyc(); rst_n = 1'b1; cyc();
    peek(8'h0A, d); check("R3 mode kept", d, 8'h2F);
    peek(8'h0B, d); check("R3 enables partly cleared", d, 8'h87);
    peek(8'h0C, d); check("R3 flags cleared", d, 8'h00);
    check("R3 irq cleared", irq, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule